// File: doc/BRIEF.md
# Antilogarithm Shifter

This block turns a fixed-point base-2 logarithm back into an approximate binary integer. The logarithm arrives in two parts. The characteristic `k` is the integer part. The fraction `f` is an unsigned FRAC_W-bit value read as `0.f`. The block computes `floor((1 + 0.f) * 2^k)`. Put another way, a one is placed at bit `k`, and the most significant fraction bits fill the positions directly beneath it. Fraction bits that would land below bit 0 are dropped. No lookup table and no interpolation are used.

Typical use is the last step of a logarithmic multiplier or divider. The exponent sum and the mantissa sum from the earlier stages are presented with `inValid`. One cycle later the result appears on `outData`, together with `outValid`.

A separate zero input marks an operand that is exactly zero, since the logarithm cannot represent zero. A characteristic too large for the output width saturates the result and raises an overflow flag.

Top module: `antilog_shifter`

## Requirements
- R1: For a non-zero, non-overflowing request, the highest set bit of `outData` is at position `inChar`.
- R2: For `inChar < OUT_W` with `inZero` low, `outData` equals `floor(((2^FRAC_W + inFrac) * 2^inChar) / 2^FRAC_W)`, taken over OUT_W bits. The fraction bits sit under the leading one, most significant first, and the bits below bit 0 are truncated.
- R3: When `inChar >= OUT_W` and `inZero` is low, `outData` is all ones and `outOvf` is 1. For any other accepted request, `outOvf` is 0.
- R4: When `inZero` is 1, `outData` is 0 and `outOvf` is 0, whatever the values of `inChar` and `inFrac`. This takes priority over R3.
- R5: `outValid` is high for exactly one cycle, in the cycle after each cycle in which `inValid` is high.
- R6: While `inValid` is low, `outData` and `outOvf` keep their last values, even if `inChar`, `inFrac` and `inZero` change.
- R7: After reset, `outValid`, `outData` and `outOvf` are all 0.
- R8: A characteristic of 0 yields `outData` equal to 1, for any fraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Request strobe; inputs are sampled on this cycle |
| inZero | input | 1 | Operand is zero; forces a zero result |
| inChar | input | CHAR_W (5) | Characteristic, the integer part of the logarithm |
| inFrac | input | FRAC_W (16) | Fraction, the fractional part of the logarithm |
| outValid | output | 1 | Result strobe, one cycle after `inValid` |
| outData | output | OUT_W (24) | Reconstructed integer |
| outOvf | output | 1 | Characteristic out of range; `outData` saturated |

## Verification
Several fixed cases separate different errors:
- An all-ones fraction at characteristic 0 and at the top in-range characteristic exposes off-by-one errors in the stage count and the truncation edge.
- Characteristics just at and well above the output width separate the overflow compare from the shift path.
- A zero flag combined with an overflowing characteristic checks which of the two wins.

Several hundred seeded random characteristic/fraction pairs then cover every shift amount against a reference computed in the bench. Idle cycles with scrambled inputs show that the held result ignores them.

// File: rtl/antilog_pkg.sv
package antilog_pkg;
  // Strobes from control to datapath, valid in the request cycle
  typedef struct packed {
    logic load;   // capture a new result
    logic clear;  // force zero
    logic sat;    // force all ones
  } ctrlStrobes_t;
endpackage

// File: rtl/antilog_stage.sv
// One conditional single-position stage. Stages sit at fixed indexes.
// Stage IDX shifts right by one while inChar + IDX < OUT_W - 1. A chain of
// OUT_W-1 stages therefore shifts by OUT_W-1-inChar in total.
module antilog_stage #(
  parameter int OUT_W  = 24,
  parameter int CHAR_W = 5,
  parameter int IDX    = 0
) (
  input  logic [CHAR_W-1:0] inChar,
  input  logic [OUT_W-1:0]  stageIn,
  output logic [OUT_W-1:0]  stageOut
);
  logic doShift;
  always_comb begin
    doShift  = (int'(inChar) + IDX) < (OUT_W - 1);
    stageOut = doShift ? (stageIn >> 1) : stageIn;
  end
endmodule

// File: rtl/antilog_ctrl.sv
module antilog_ctrl
  import antilog_pkg::*;
#(
  parameter int OUT_W  = 24,
  parameter int CHAR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              inZero,
  input  logic [CHAR_W-1:0] inChar,
  output ctrlStrobes_t      strobes,
  output logic              outValid,
  output logic              outOvf
);
  logic outOfRange;

  always_comb begin
    outOfRange    = int'(inChar) >= OUT_W;
    strobes.load  = inValid;
    strobes.clear = inValid & inZero;
    strobes.sat   = inValid & ~inZero & outOfRange;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outOvf   <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) outOvf <= strobes.sat;
    end
  end

  // R5: a result strobe follows every request
  p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  // R5: no result strobe without a request
  p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  // R6: the overflow flag holds while idle
  p_ovf_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(outOvf));
  // R4: a zero operand never reports overflow
  p_zero_no_ovf_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && inZero) |=> !outOvf);
endmodule

// File: rtl/antilog_datapath.sv
module antilog_datapath
  import antilog_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 24,
  parameter int CHAR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [CHAR_W-1:0] inChar,
  input  logic [FRAC_W-1:0] inFrac,
  output logic [OUT_W-1:0]  outData
);
  localparam int NSTAGE = OUT_W - 1;

  logic [OUT_W-1:0] chain [NSTAGE+1];

  // Seed: implicit one at the top, fraction beneath it (as if inChar = OUT_W-1)
  generate
    if (FRAC_W + 1 >= OUT_W) begin : g_seed_trunc
      assign chain[0] = {1'b1, inFrac[FRAC_W-1 -: OUT_W-1]};
    end else begin : g_seed_pad
      assign chain[0] = {1'b1, inFrac, {(OUT_W-1-FRAC_W){1'b0}}};
    end
  endgenerate

  genvar gi;
  generate
    for (gi = 0; gi < NSTAGE; gi++) begin : g_stage
      antilog_stage #(.OUT_W(OUT_W), .CHAR_W(CHAR_W), .IDX(gi)) u_stage (
        .inChar  (inChar),
        .stageIn (chain[gi]),
        .stageOut(chain[gi+1])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outData <= '0;
    end else if (strobes.load) begin
      if (strobes.clear)    outData <= '0;
      else if (strobes.sat) outData <= '1;
      else                  outData <= chain[NSTAGE];
    end
  end

  // R3: saturation yields all ones
  p_sat_ones_r3: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.sat |=> (&outData));
  // R4: zero operand clears the result
  p_zero_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (outData == '0));
  // R6: result holds without a load
  p_data_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.load |=> $stable(outData));
endmodule

// File: rtl/antilog_shifter.sv
module antilog_shifter
  import antilog_pkg::*;
#(
  parameter int FRAC_W = 16,
  parameter int OUT_W  = 24,
  parameter int CHAR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              inZero,
  input  logic [CHAR_W-1:0] inChar,
  input  logic [FRAC_W-1:0] inFrac,
  output logic              outValid,
  output logic [OUT_W-1:0]  outData,
  output logic              outOvf
);
  ctrlStrobes_t strobes;

  antilog_ctrl #(.OUT_W(OUT_W), .CHAR_W(CHAR_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .inZero  (inZero),
    .inChar  (inChar),
    .strobes (strobes),
    .outValid(outValid),
    .outOvf  (outOvf)
  );

  antilog_datapath #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .CHAR_W(CHAR_W)) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobes(strobes),
    .inChar (inChar),
    .inFrac (inFrac),
    .outData(outData)
  );

  // R1: leading one sits at the requested characteristic
  p_lead_one_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outOvf && (outData != '0)) |-> ((outData >> $past(inChar)) == 1));
  // R3: overflow flag implies saturated data
  p_ovf_sat_r3: assert property (@(posedge clk) disable iff (!rst_n)
    outOvf |-> (&outData));
endmodule

// File: tb/tb_antilog_shifter.sv
`timescale 1ns/1ps
module tb_antilog_shifter;
  localparam int FRAC_W = 16;
  localparam int OUT_W  = 24;
  localparam int CHAR_W = 5;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              inValid = 1'b0;
  logic              inZero = 1'b0;
  logic [CHAR_W-1:0] inChar = '0;
  logic [FRAC_W-1:0] inFrac = '0;
  logic              outValid;
  logic [OUT_W-1:0]  outData;
  logic              outOvf;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  antilog_shifter #(.FRAC_W(FRAC_W), .OUT_W(OUT_W), .CHAR_W(CHAR_W)) dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inZero(inZero),
    .inChar(inChar), .inFrac(inFrac),
    .outValid(outValid), .outData(outData), .outOvf(outOvf)
  );

  function automatic logic [OUT_W-1:0] expData(input int k, input logic [FRAC_W-1:0] f,
                                               input logic z);
    logic [63:0] v;
    if (z) return '0;
    if (k >= OUT_W) return '1;
    v = {{(63-FRAC_W){1'b0}}, 1'b1, f};
    v = v << k;
    return v[FRAC_W +: OUT_W];
  endfunction

  function automatic logic expOvf(input int k, input logic z);
    return !z && (k >= OUT_W);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue one request, check the result and the single-cycle strobe
  task automatic apply(input string req, input int k, input logic [FRAC_W-1:0] f,
                       input logic z);
    logic [OUT_W-1:0] held;
    @(negedge clk);
    inValid = 1'b1; inZero = z; inChar = CHAR_W'(k); inFrac = f;
    @(posedge clk); #1;
    check({req, " data"}, 64'(outData), 64'(expData(k, f, z)));
    check({req, " ovf"}, 64'(outOvf), 64'(expOvf(k, z)));
    check("R5 valid rise", 64'(outValid), 64'd1);
    held = outData;
    @(negedge clk);
    inValid = 1'b0;
    @(posedge clk); #1;
    check("R5 valid pulse", 64'(outValid), 64'd0);
    check("R6 data hold", 64'(outData), 64'(held));
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    logic [OUT_W-1:0] keep;
    logic keepOvf;
    seed = $urandom(32'd4242);
    repeat (3) @(posedge clk);
    #1;
    // R7 reset state
    check("R7 valid", 64'(outValid), 64'd0);
    check("R7 data", 64'(outData), 64'd0);
    check("R7 ovf", 64'(outOvf), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Directed corners
    apply("R1 k14", 14, 16'h9CD4, 1'b0);          // expect 0x006735
    check("R1 k14 value", 64'(outData), 64'h006735);
    apply("R8 k0 ones", 0, 16'hFFFF, 1'b0);
    check("R8 k0 value", 64'(outData), 64'd1);
    apply("R8 k0 zero frac", 0, 16'h0000, 1'b0);
    apply("R2 top k23", 23, 16'hFFFF, 1'b0);      // expect 0xFFFF80
    check("R2 top value", 64'(outData), 64'hFFFF80);
    apply("R2 k16", 16, 16'h8001, 1'b0);
    apply("R2 k1", 1, 16'h8000, 1'b0);            // expect 3
    apply("R3 k24", 24, 16'h1234, 1'b0);
    apply("R3 k31", 31, 16'h0000, 1'b0);
    apply("R4 zero over range", 31, 16'hFFFF, 1'b1);
    apply("R4 zero in range", 10, 16'hABCD, 1'b1);
    apply("R3 after zero", 25, 16'h0F0F, 1'b0);

    // R6: idle cycles with scrambled inputs leave outputs untouched
    keep = outData; keepOvf = outOvf;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      inChar = CHAR_W'($urandom); inFrac = FRAC_W'($urandom); inZero = 1'($urandom);
      @(posedge clk); #1;
      check("R6 idle data", 64'(outData), 64'(keep));
      check("R6 idle ovf", 64'(outOvf), 64'(keepOvf));
    end

    // Every characteristic once with a random fraction (R1/R2/R3)
    for (int k = 0; k < (1 << CHAR_W); k++) begin
      apply("R2 sweep", k, FRAC_W'($urandom), 1'b0);
    end

    // Constrained random
    for (int i = 0; i < 400; i++) begin
      int k;
      logic z;
      k = int'($urandom % (1 << CHAR_W));
      z = (($urandom % 16) == 0);
      apply("R2 random", k, FRAC_W'($urandom), z);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule